// File: doc/BRIEF.md
# Operand Forwarding and Load-Use Interlock

This block is the hazard logic of a five-stage in-order integer pipeline with fetch, decode, execute, memory and write-back stages. Every register read happens in decode and every register write happens in write-back, so the only ordering problem left is a read that wants a value not yet written. The block is purely combinational. It looks at the source register numbers of the instruction in execute and of the instruction in decode. It compares them with the destination register numbers and write enables held in the execute/memory and memory/write-back pipeline registers. From these comparisons it produces the ALU operand multiplexer selects and the store-data select used in the memory stage.

Most dependences are resolved by forwarding alone, with no lost cycle. One case cannot be resolved that way: a load in execute whose result is needed by the ALU of the very next instruction. In that case the block raises a hold for the program counter and the fetch/decode register, and a flush that zeroes the control fields entering execute. This inserts exactly one bubble. A store that only needs the loaded value as its data does not stall. That value is steered to the store-data input one stage later instead.

Top module: `fwd_interlock`

## Requirements
- R1: When the execute/memory register has its write enable high and a nonzero destination equal to an execute source, that operand's select is 2'b10.
- R2: When only the memory/write-back register (write enable high, nonzero destination) matches an execute source, that operand's select is 2'b01.
- R3: When both pipeline registers match the same execute source, the select is 2'b10, because the newer result takes priority.
- R4: With no qualifying match, the operand select is 2'b00 (register file). The code 2'b11 never appears.
- R5: A destination of register 0 is never matched, whatever the write enables are.
- R6: A pipeline register whose write enable is low, as for stores and branches, is never matched.
- R7: A load in execute with a nonzero destination equal to a decode source that feeds the ALU raises hold and flush together. The ALU-fed sources are source 1 of any instruction that uses it, and source 2 when the instruction is not a store.
- R8: A load in execute whose destination matches only the store-data source (source 2) of a store in decode raises no hold.
- R9: A store in the memory stage whose data register equals the nonzero, write-enabled destination of the memory/write-back register raises the store-data select.
- R10: Hold is never raised by a non-load in execute, nor for a decode source marked unused. Flush always equals hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dec_rs1 | input | REG_W | Source 1 number of the instruction in decode |
| dec_rs2 | input | REG_W | Source 2 number of the instruction in decode |
| dec_use_rs1 | input | 1 | Decode instruction reads source 1 |
| dec_use_rs2 | input | 1 | Decode instruction reads source 2 |
| dec_is_store | input | 1 | Decode instruction is a store (source 2 is store data) |
| ex_rs1 | input | REG_W | Source 1 number of the instruction in execute |
| ex_rs2 | input | REG_W | Source 2 number of the instruction in execute |
| ex_rd | input | REG_W | Destination of the instruction in execute |
| ex_wr | input | 1 | Execute instruction writes a register |
| ex_load | input | 1 | Execute instruction is a load |
| mem_rd | input | REG_W | Destination held in the execute/memory register |
| mem_wr | input | 1 | Write enable held in the execute/memory register |
| mem_store | input | 1 | Memory-stage instruction is a store |
| mem_rs2 | input | REG_W | Store-data register number of the memory-stage instruction |
| wb_rd | input | REG_W | Destination held in the memory/write-back register |
| wb_wr | input | 1 | Write enable held in the memory/write-back register |
| fwd_a | output | 2 | ALU operand A select: 00 file, 10 exec/mem, 01 mem/wb |
| fwd_b | output | 2 | ALU operand B select, same encoding |
| st_fwd | output | 1 | Store data taken from the memory/write-back register |
| hold | output | 1 | Freeze program counter and fetch/decode register |
| flush | output | 1 | Zero control fields entering execute |

## Verification
On every input change, the assertions check several properties. Selects never point at register 0 or at a stage whose write enable is low, and the code 11 never appears. Hold needs a load in execute, flush tracks hold, and the store-data select needs a store in the memory stage. Only the bench's scenarios show the rest. That includes priority when both stages match, the exact split between an address-source dependence on a load (stall) and a store-data dependence (no stall), and the absence of a stall for later consumers of a load. A randomized phase over a small register range makes these comparisons collide often.

// File: rtl/fwd_interlock.sv
module fwd_interlock #(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] dec_rs1,
  input  logic [REG_W-1:0] dec_rs2,
  input  logic             dec_use_rs1,
  input  logic             dec_use_rs2,
  input  logic             dec_is_store,
  input  logic [REG_W-1:0] ex_rs1,
  input  logic [REG_W-1:0] ex_rs2,
  input  logic [REG_W-1:0] ex_rd,
  input  logic             ex_wr,
  input  logic             ex_load,
  input  logic [REG_W-1:0] mem_rd,
  input  logic             mem_wr,
  input  logic             mem_store,
  input  logic [REG_W-1:0] mem_rs2,
  input  logic [REG_W-1:0] wb_rd,
  input  logic             wb_wr,
  output logic [1:0]       fwd_a,
  output logic [1:0]       fwd_b,
  output logic             st_fwd,
  output logic             hold,
  output logic             flush
);

  localparam logic [1:0] SEL_RF  = 2'b00;
  localparam logic [1:0] SEL_MEM = 2'b10;
  localparam logic [1:0] SEL_WB  = 2'b01;

  logic mem_live, wb_live, ld_live;
  assign mem_live = mem_wr && (mem_rd != '0);
  assign wb_live  = wb_wr  && (wb_rd  != '0);
  assign ld_live  = ex_load && ex_wr && (ex_rd != '0);

  function automatic logic [1:0] pick(input logic [REG_W-1:0] src,
                                      input logic m_ok, input logic [REG_W-1:0] m_rd,
                                      input logic w_ok, input logic [REG_W-1:0] w_rd);
    if (m_ok && m_rd == src)      return SEL_MEM;
    else if (w_ok && w_rd == src) return SEL_WB;
    else                          return SEL_RF;
  endfunction

  assign fwd_a  = pick(ex_rs1, mem_live, mem_rd, wb_live, wb_rd);
  assign fwd_b  = pick(ex_rs2, mem_live, mem_rd, wb_live, wb_rd);
  assign st_fwd = mem_store && wb_live && (mem_rs2 == wb_rd);

  logic hit1, hit2;
  assign hit1  = dec_use_rs1 && (dec_rs1 == ex_rd);
  assign hit2  = dec_use_rs2 && !dec_is_store && (dec_rs2 == ex_rd);
  assign hold  = ld_live && (hit1 || hit2);
  assign flush = hold;

  always_comb begin
    if (!$isunknown({fwd_a, fwd_b, st_fwd, hold, flush, ex_load, mem_store,
                     mem_wr, wb_wr, mem_rd, wb_rd})) begin
      a_r4_no_code11: assert (fwd_a != 2'b11 && fwd_b != 2'b11);
      a_r5_not_r0_a: assert (!(fwd_a == SEL_MEM && mem_rd == '0) && !(fwd_a == SEL_WB && wb_rd == '0));
      a_r6_need_wr_b: assert (!(fwd_b == SEL_MEM && !mem_wr) && !(fwd_b == SEL_WB && !wb_wr));
      a_r7_hold_needs_load: assert (!hold || ex_load);
      a_r10_flush_tracks: assert (flush == hold);
      a_r9_st_needs_store: assert (!st_fwd || mem_store);
    end
  end

endmodule

// File: tb/test_fwd_interlock.sv
module test_fwd_interlock;
  localparam int W = 5;
  logic clk = 0, rst_n = 0;
  always #2 clk = ~clk;

  logic [W-1:0] dec_rs1, dec_rs2, ex_rs1, ex_rs2, ex_rd, mem_rd, mem_rs2, wb_rd;
  logic dec_use_rs1, dec_use_rs2, dec_is_store, ex_wr, ex_load, mem_wr, mem_store, wb_wr;
  logic [1:0] fwd_a, fwd_b;
  logic st_fwd, hold, flush;
  int checks = 0, errors = 0;
  bit done = 0;

  fwd_interlock #(.REG_W(W)) i_fwd_interlock (.*);

  function automatic logic [1:0] exp_sel(logic [W-1:0] s);
    logic [1:0] r;
    r = 2'b00;
    if (wb_wr && wb_rd != 0 && wb_rd == s) r = 2'b01;
    if (mem_wr && mem_rd != 0 && mem_rd == s) r = 2'b10;
    return r;
  endfunction

  function automatic logic exp_hold();
    logic a, b;
    if (!(ex_load && ex_wr) || ex_rd == 0) return 1'b0;
    a = dec_use_rs1 && dec_rs1 == ex_rd;
    b = dec_use_rs2 && dec_rs2 == ex_rd && !dec_is_store;
    return a | b;
  endfunction

  task automatic chk(string req, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle();
    {dec_rs1, dec_rs2, ex_rs1, ex_rs2, ex_rd, mem_rd, mem_rs2, wb_rd} = '0;
    {dec_use_rs1, dec_use_rs2, dec_is_store, ex_wr, ex_load, mem_wr, mem_store, wb_wr} = '0;
  endtask

  task automatic full(string req);
    #1;
    chk(req, {2'b0, fwd_a}, {2'b0, exp_sel(ex_rs1)});
    chk(req, {2'b0, fwd_b}, {2'b0, exp_sel(ex_rs2)});
    chk(req, {3'b0, hold}, {3'b0, exp_hold()});
    chk("R10", {3'b0, flush}, {3'b0, hold});
    chk("R9", {3'b0, st_fwd}, {3'b0, mem_store && wb_wr && wb_rd != 0 && wb_rd == mem_rs2});
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd502));
    idle();
    repeat (2) @(posedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    chk("R4 idle", {fwd_a, fwd_b}, 4'h0);
    chk("R10 idle", {2'b0, hold, flush}, 4'h0);

    @(negedge clk); idle(); mem_wr = 1; mem_rd = 3; ex_rs1 = 3; #1;
    chk("R1", {2'b0, fwd_a}, 4'b0010);
    @(negedge clk); idle(); wb_wr = 1; wb_rd = 7; ex_rs2 = 7; #1;
    chk("R2", {2'b0, fwd_b}, 4'b0001);
    @(negedge clk); idle(); wb_wr = 1; wb_rd = 4; mem_wr = 1; mem_rd = 4; ex_rs1 = 4; ex_rs2 = 4; #1;
    chk("R3", {fwd_a, fwd_b}, 4'b1010);
    @(negedge clk); idle(); mem_wr = 1; wb_wr = 1; ex_rs1 = 0; ex_rs2 = 0; #1;
    chk("R5", {fwd_a, fwd_b}, 4'h0);
    @(negedge clk); idle(); mem_rd = 6; wb_rd = 6; ex_rs1 = 6; #1;
    chk("R6", {2'b0, fwd_a}, 4'h0);
    @(negedge clk); idle(); ex_load = 1; ex_wr = 1; ex_rd = 9; dec_use_rs1 = 1; dec_rs1 = 9; #1;
    chk("R7 rs1", {2'b0, hold, flush}, 4'b0011);
    @(negedge clk); dec_use_rs1 = 0; dec_use_rs2 = 1; dec_rs2 = 9; #1;
    chk("R7 rs2", {3'b0, hold}, 4'b0001);
    @(negedge clk); dec_is_store = 1; #1;
    chk("R8", {3'b0, hold}, 4'b0000);
    @(negedge clk); dec_use_rs1 = 1; dec_rs1 = 9; #1;
    chk("R7 store base", {3'b0, hold}, 4'b0001);
    @(negedge clk); idle(); mem_store = 1; mem_rs2 = 9; wb_wr = 1; wb_rd = 9; #1;
    chk("R9", {3'b0, st_fwd}, 4'b0001);
    @(negedge clk); wb_rd = 0; mem_rs2 = 0; #1;
    chk("R9 r0", {3'b0, st_fwd}, 4'b0000);
    @(negedge clk); idle(); ex_wr = 1; ex_rd = 5; dec_use_rs1 = 1; dec_rs1 = 5; #1;
    chk("R10 alu", {3'b0, hold}, 4'b0000);
    @(negedge clk); ex_load = 1; dec_use_rs1 = 0; #1;
    chk("R10 unused", {3'b0, hold}, 4'b0000);
    @(negedge clk); ex_rd = 0; dec_use_rs1 = 1; dec_rs1 = 0; #1;
    chk("R5 load r0", {3'b0, hold}, 4'b0000);

    for (int n = 0; n < 3000; n++) begin
      @(negedge clk);
      dec_rs1 = W'($urandom_range(0, 3)); dec_rs2 = W'($urandom_range(0, 3));
      ex_rs1 = W'($urandom_range(0, 3)); ex_rs2 = W'($urandom_range(0, 3));
      ex_rd = W'($urandom_range(0, 3)); mem_rd = W'($urandom_range(0, 3));
      mem_rs2 = W'($urandom_range(0, 3)); wb_rd = W'($urandom_range(0, 3));
      {dec_use_rs1, dec_use_rs2, dec_is_store, ex_wr, ex_load, mem_wr, mem_store, wb_wr}
        = 8'($urandom);
      full("R1 R2 R3 R4 R5 R6 R7 R8");
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule